// File: doc/BRIEF.md
# Tag-Wakeup Issue Buffer

This block is a four-slot holding buffer for an out-of-order core. Instructions wait in it until both of their source operands have been produced. A slot is first claimed by a separate select step, which hands back the lowest free index. The entry is then written into that slot with an insert. Each source operand carries a tag. A tag of zero means the value is already present. A nonzero tag means the operand is still outstanding.

Completed results are broadcast as a tag/value pair. Every waiting operand whose tag matches takes the value, and its tag is cleared. An entry whose two tags are both zero is ready. The buffer reports ready entries as one bitmask per configured group of operation types. Each mask comes with a flag that is high only while the mask is nonzero.

An execution unit takes an entry by index. It receives the entry's payload in the same cycle, and the slot becomes free again.

Top module: `issue_station`

## Requirements
- R1: After reset no slot is reserved or full, `sel_ready_o` is 1, `sel_idx_o` is 0, and every ready mask and ready flag is 0.
- R2: `sel_idx_o` is the lowest-numbered unreserved slot. A select transfer (`sel_valid_i` and `sel_ready_o` both high at a clock edge) reserves that slot. `sel_ready_o` is 0 while all four slots are reserved.
- R3: A slot freed by a take becomes selectable again. Taking slot 0 makes the next select return index 0.
- R4: Insert writes the payload into slot `ins_idx_i` and marks it full. A full slot whose two source tags are both zero shows as ready from the cycle after the insert.
- R5: On an update, every full slot with source-1 tag equal to the broadcast tag (nonzero) stores the value as source-1 value and clears that tag. Source 2 is handled the same way and independently, so one update can wake both operands of a slot, and of several slots at once.
- R6: `take_ready_o` is 1 only when slot `take_idx_i` is full. While it is 1, the take outputs carry that slot's payload in the same cycle. A take transfer frees the slot, and its ready bit drops in the next cycle. A take request on a slot that is not full changes nothing.
- R7: Group g's mask is bits [g*4+3:g*4] of `rdy_mask_o`. Bit i is set when slot i is ready and bit `op` of group g's field in `GROUP_SETS` is 1, where `op` is the slot's op type. Each group's field is 16 bits wide, group 0 in the low bits. By default group 0 covers op types 1 and 2 and group 1 covers op types 3 and 4. With `NUM_GROUPS`=1 and an all-ones field, a single mask covers every op type.
- R8: `rdy_valid_o[g]` is 1 exactly when group g's mask is nonzero.
- R9: When an update and an insert happen in the same cycle, the inserted source tags are compared against the broadcast tag, so a matching operand is woken and not left waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid_i | input | 1 | Request to reserve a slot |
| sel_ready_o | output | 1 | A free slot exists |
| sel_idx_o | output | 2 | Index of the slot that a select would reserve |
| ins_valid_i | input | 1 | Insert strobe (always accepted) |
| ins_idx_i | input | 2 | Slot to write |
| ins_src1_tag_i | input | TAG_W | Source-1 tag, 0 if present |
| ins_src2_tag_i | input | TAG_W | Source-2 tag, 0 if present |
| ins_dst_tag_i | input | TAG_W | Destination tag |
| ins_rob_i | input | ROB_W | Reorder-buffer id |
| ins_op_i | input | OPT_W | Operation type |
| ins_f3_i | input | 3 | Function field, 3 bits |
| ins_f7_i | input | 7 | Function field, 7 bits |
| ins_src1_val_i | input | VAL_W | Source-1 value |
| ins_src2_val_i | input | VAL_W | Source-2 value |
| ins_imm_i | input | VAL_W | Immediate |
| ins_pc_i | input | VAL_W | Program counter |
| upd_valid_i | input | 1 | Result broadcast strobe (always accepted) |
| upd_tag_i | input | TAG_W | Broadcast tag |
| upd_val_i | input | VAL_W | Broadcast value |
| take_valid_i | input | 1 | Request to remove a slot |
| take_idx_i | input | 2 | Slot to remove |
| take_ready_o | output | 1 | Selected slot is full |
| take_src1_val_o | output | VAL_W | Payload: source-1 value |
| take_src2_val_o | output | VAL_W | Payload: source-2 value |
| take_dst_tag_o | output | TAG_W | Payload: destination tag |
| take_rob_o | output | ROB_W | Payload: reorder-buffer id |
| take_op_o | output | OPT_W | Payload: op type |
| take_f3_o | output | 3 | Payload: 3-bit function field |
| take_f7_o | output | 7 | Payload: 7-bit function field |
| take_imm_o | output | VAL_W | Payload: immediate |
| take_pc_o | output | VAL_W | Payload: program counter |
| rdy_mask_o | output | NUM_GROUPS*4 | Per-group ready masks |
| rdy_valid_o | output | NUM_GROUPS | Per-group mask-nonzero flags |

Select and take use valid/ready. A transfer happens only at an edge where both are high, and a requester holds its request until it is accepted. Insert and update have no back-pressure.

## Verification
Insert and update can fall in the same cycle. The bench provokes this by writing a slot while a broadcast carries the slot's source-1 tag, and by holding the source-2 tag for a later broadcast. It judges the result by three things. The slot must stay out of the ready mask until the second broadcast. It must then appear in the mask. A take must return the first broadcast's value as source-1 value, which shows the wakeup in the insert cycle was not lost.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  localparam int F3_W = 3;
  localparam int F7_W = 7;
  localparam int NUM_OPS = 2;  // source operands per entry
endpackage

// File: rtl/rsv_alloc.sv
module rsv_alloc #(
  parameter int N = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     reserved_i,
  output logic             any_free_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!reserved_i[i]) idx_o = i[IDX_W-1:0];
  end
  assign any_free_o = ~&reserved_i;

  // picked slot is free and every slot below it is taken
  p_pick_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_free_o |-> (!reserved_i[idx_o] &&
                    ((reserved_i | ~((N'(1) << idx_o) - N'(1))) == {N{1'b1}})));
endmodule

// File: rtl/rsv_slot.sv
module rsv_slot #(
  parameter int TAG_W = 6,
  parameter int VAL_W = 32,
  parameter int ROB_W = 5,
  parameter int OPT_W = 4,
  localparam int PL_W = 3*TAG_W + ROB_W + OPT_W + rsv_pkg::F3_W + rsv_pkg::F7_W + 4*VAL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reserve_i,
  input  logic             insert_i,
  input  logic             take_i,
  input  logic             upd_valid_i,
  input  logic [TAG_W-1:0] upd_tag_i,
  input  logic [VAL_W-1:0] upd_val_i,
  input  logic [PL_W-1:0]  ins_pl_i,
  output logic             reserved_o,
  output logic             full_o,
  output logic             ready_o,
  output logic [PL_W-1:0]  pl_o
);
  typedef struct packed {
    logic [TAG_W-1:0]         src1_tag;
    logic [TAG_W-1:0]         src2_tag;
    logic [TAG_W-1:0]         dst_tag;
    logic [ROB_W-1:0]         rob;
    logic [OPT_W-1:0]         op;
    logic [rsv_pkg::F3_W-1:0] f3;
    logic [rsv_pkg::F7_W-1:0] f7;
    logic [VAL_W-1:0]         src1_val;
    logic [VAL_W-1:0]         src2_val;
    logic [VAL_W-1:0]         imm;
    logic [VAL_W-1:0]         pc;
  } pl_t;

  pl_t  cur_q, base, nxt, ins_pl;
  logic res_q, full_q, live;

  assign ins_pl = pl_t'(ins_pl_i);

  always_comb begin
    base = insert_i ? ins_pl : cur_q;
    nxt  = base;
    live = insert_i | full_q;
    if (upd_valid_i && live && upd_tag_i != '0) begin
      if (base.src1_tag == upd_tag_i) begin
        nxt.src1_tag = '0;
        nxt.src1_val = upd_val_i;
      end
      if (base.src2_tag == upd_tag_i) begin
        nxt.src2_tag = '0;
        nxt.src2_val = upd_val_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= 1'b0;
      full_q <= 1'b0;
      cur_q  <= '0;
    end else if (take_i) begin
      res_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (reserve_i) res_q <= 1'b1;
      if (insert_i) begin
        res_q  <= 1'b1;
        full_q <= 1'b1;
      end
      cur_q <= nxt;
    end
  end

  assign reserved_o = res_q;
  assign full_o     = full_q;
  assign ready_o    = full_q && cur_q.src1_tag == '0 && cur_q.src2_tag == '0;
  assign pl_o       = cur_q;

  p_full_has_res_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> res_q);

  p_take_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (!full_q && !res_q));

  p_wake_src1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_i && full_q && !insert_i && !take_i && upd_tag_i != '0 &&
     cur_q.src1_tag == upd_tag_i)
    |=> (cur_q.src1_tag == '0 && cur_q.src1_val == $past(upd_val_i)));

  p_wake_src2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid_i && full_q && !insert_i && !take_i && upd_tag_i != '0 &&
     cur_q.src2_tag == upd_tag_i)
    |=> (cur_q.src2_tag == '0 && cur_q.src2_val == $past(upd_val_i)));

  p_ins_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (insert_i && !take_i && upd_valid_i && upd_tag_i != '0 &&
     ins_pl.src1_tag == upd_tag_i)
    |=> (cur_q.src1_tag == '0 && full_q));
endmodule

// File: rtl/rsv_group.sv
module rsv_group #(
  parameter int N = 4,
  parameter int OPT_W = 4,
  parameter logic [(1<<OPT_W)-1:0] TYPE_SET = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       ready_i,
  input  logic [N*OPT_W-1:0] ops_i,
  output logic [N-1:0]       mask_o,
  output logic               valid_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign mask_o[i] = ready_i[i] && TYPE_SET[ops_i[i*OPT_W +: OPT_W]];
  end
  assign valid_o = |mask_o;

  p_mask_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o & ~ready_i) == '0);
endmodule

// File: rtl/issue_station.sv
module issue_station #(
  parameter int N          = 4,
  parameter int TAG_W      = 6,
  parameter int VAL_W      = 32,
  parameter int ROB_W      = 5,
  parameter int OPT_W      = 4,
  parameter int NUM_GROUPS = 2,
  parameter logic [NUM_GROUPS*(1<<OPT_W)-1:0] GROUP_SETS = 32'h0018_0006,
  localparam int IDX_W = $clog2(N),
  localparam int F3_W  = rsv_pkg::F3_W,
  localparam int F7_W  = rsv_pkg::F7_W,
  localparam int SET_W = 1 << OPT_W,
  localparam int PL_W  = 3*TAG_W + ROB_W + OPT_W + F3_W + F7_W + 4*VAL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_valid_i,
  output logic                    sel_ready_o,
  output logic [IDX_W-1:0]        sel_idx_o,
  input  logic                    ins_valid_i,
  input  logic [IDX_W-1:0]        ins_idx_i,
  input  logic [TAG_W-1:0]        ins_src1_tag_i,
  input  logic [TAG_W-1:0]        ins_src2_tag_i,
  input  logic [TAG_W-1:0]        ins_dst_tag_i,
  input  logic [ROB_W-1:0]        ins_rob_i,
  input  logic [OPT_W-1:0]        ins_op_i,
  input  logic [F3_W-1:0]         ins_f3_i,
  input  logic [F7_W-1:0]         ins_f7_i,
  input  logic [VAL_W-1:0]        ins_src1_val_i,
  input  logic [VAL_W-1:0]        ins_src2_val_i,
  input  logic [VAL_W-1:0]        ins_imm_i,
  input  logic [VAL_W-1:0]        ins_pc_i,
  input  logic                    upd_valid_i,
  input  logic [TAG_W-1:0]        upd_tag_i,
  input  logic [VAL_W-1:0]        upd_val_i,
  input  logic                    take_valid_i,
  input  logic [IDX_W-1:0]        take_idx_i,
  output logic                    take_ready_o,
  output logic [VAL_W-1:0]        take_src1_val_o,
  output logic [VAL_W-1:0]        take_src2_val_o,
  output logic [TAG_W-1:0]        take_dst_tag_o,
  output logic [ROB_W-1:0]        take_rob_o,
  output logic [OPT_W-1:0]        take_op_o,
  output logic [F3_W-1:0]         take_f3_o,
  output logic [F7_W-1:0]         take_f7_o,
  output logic [VAL_W-1:0]        take_imm_o,
  output logic [VAL_W-1:0]        take_pc_o,
  output logic [NUM_GROUPS*N-1:0] rdy_mask_o,
  output logic [NUM_GROUPS-1:0]   rdy_valid_o
);
  logic [N-1:0]       reserved, full, ready;
  logic [PL_W-1:0]    pl [N];
  logic [N*OPT_W-1:0] ops;
  logic [PL_W-1:0]    ins_pl, take_pl;
  logic               sel_fire, take_fire;

  assign ins_pl = {ins_src1_tag_i, ins_src2_tag_i, ins_dst_tag_i, ins_rob_i, ins_op_i,
                   ins_f3_i, ins_f7_i, ins_src1_val_i, ins_src2_val_i, ins_imm_i, ins_pc_i};

  rsv_alloc #(.N(N)) u_alloc (
    .clk(clk), .rst_n(rst_n), .reserved_i(reserved),
    .any_free_o(sel_ready_o), .idx_o(sel_idx_o));

  assign sel_fire     = sel_valid_i && sel_ready_o;
  assign take_ready_o = full[take_idx_i];
  assign take_fire    = take_valid_i && take_ready_o;

  for (genvar i = 0; i < N; i++) begin : g_slot
    rsv_slot #(.TAG_W(TAG_W), .VAL_W(VAL_W), .ROB_W(ROB_W), .OPT_W(OPT_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .reserve_i(sel_fire && sel_idx_o == IDX_W'(i)),
      .insert_i(ins_valid_i && ins_idx_i == IDX_W'(i)),
      .take_i(take_fire && take_idx_i == IDX_W'(i)),
      .upd_valid_i(upd_valid_i), .upd_tag_i(upd_tag_i), .upd_val_i(upd_val_i),
      .ins_pl_i(ins_pl),
      .reserved_o(reserved[i]), .full_o(full[i]), .ready_o(ready[i]), .pl_o(pl[i]));
    // op type sits right above the two function fields
    assign ops[i*OPT_W +: OPT_W] = pl[i][4*VAL_W + F7_W + F3_W +: OPT_W];
  end

  assign take_pl = pl[take_idx_i];
  assign {take_dst_tag_o, take_rob_o, take_op_o, take_f3_o, take_f7_o,
          take_src1_val_o, take_src2_val_o, take_imm_o, take_pc_o} = take_pl[PL_W-2*TAG_W-1:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    rsv_group #(.N(N), .OPT_W(OPT_W), .TYPE_SET(GROUP_SETS[g*SET_W +: SET_W])) u_grp (
      .clk(clk), .rst_n(rst_n), .ready_i(ready), .ops_i(ops),
      .mask_o(rdy_mask_o[g*N +: N]), .valid_o(rdy_valid_o[g]));
  end

  p_sel_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fire && $countones(reserved) == N - 1) |=> !sel_ready_o);

  p_take_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_fire |=> !ready[$past(take_idx_i)]);
endmodule

// File: tb/issue_station_tb.sv
module issue_station_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic sel_valid, sel_ready; logic [1:0] sel_idx;
  logic ins_valid; logic [1:0] ins_idx;
  logic [5:0] ins_t1, ins_t2, ins_dst; logic [4:0] ins_rob; logic [3:0] ins_op;
  logic [2:0] ins_f3; logic [6:0] ins_f7;
  logic [31:0] ins_v1, ins_v2, ins_imm, ins_pc;
  logic upd_valid; logic [5:0] upd_tag; logic [31:0] upd_val;
  logic take_valid; logic [1:0] take_idx; logic take_ready;
  logic [31:0] tk_v1, tk_v2, tk_imm, tk_pc; logic [5:0] tk_dst; logic [4:0] tk_rob;
  logic [3:0] tk_op; logic [2:0] tk_f3; logic [6:0] tk_f7;
  logic [7:0] rdy_mask; logic [1:0] rdy_valid;

  int checks = 0, errors = 0;
  bit done = 0;

  issue_station dut_i (
    .clk(clk), .rst_n(rst_n),
    .sel_valid_i(sel_valid), .sel_ready_o(sel_ready), .sel_idx_o(sel_idx),
    .ins_valid_i(ins_valid), .ins_idx_i(ins_idx),
    .ins_src1_tag_i(ins_t1), .ins_src2_tag_i(ins_t2), .ins_dst_tag_i(ins_dst),
    .ins_rob_i(ins_rob), .ins_op_i(ins_op), .ins_f3_i(ins_f3), .ins_f7_i(ins_f7),
    .ins_src1_val_i(ins_v1), .ins_src2_val_i(ins_v2), .ins_imm_i(ins_imm), .ins_pc_i(ins_pc),
    .upd_valid_i(upd_valid), .upd_tag_i(upd_tag), .upd_val_i(upd_val),
    .take_valid_i(take_valid), .take_idx_i(take_idx), .take_ready_o(take_ready),
    .take_src1_val_o(tk_v1), .take_src2_val_o(tk_v2), .take_dst_tag_o(tk_dst),
    .take_rob_o(tk_rob), .take_op_o(tk_op), .take_f3_o(tk_f3), .take_f7_o(tk_f7),
    .take_imm_o(tk_imm), .take_pc_o(tk_pc),
    .rdy_mask_o(rdy_mask), .rdy_valid_o(rdy_valid));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_sel(int exp, string req);
    sel_valid = 1'b1; #1;
    chk(req, sel_ready, 1); chk(req, sel_idx, exp);
    step(); sel_valid = 1'b0;
  endtask

  task automatic drive_ins(int idx, int t1, int t2, int op, int base);
    ins_valid = 1'b1; ins_idx = 2'(idx); ins_t1 = 6'(t1); ins_t2 = 6'(t2);
    ins_dst = 6'(base); ins_rob = 5'(base); ins_op = 4'(op); ins_f3 = 3'd2; ins_f7 = 7'd4;
    ins_v1 = '0; ins_v2 = '0; ins_imm = 32'(base); ins_pc = 32'(base * 4);
  endtask

  task automatic do_ins(int idx, int t1, int t2, int op, int base);
    drive_ins(idx, t1, t2, op, base); step(); ins_valid = 1'b0;
  endtask

  task automatic do_upd(int tag, int val);
    upd_valid = 1'b1; upd_tag = 6'(tag); upd_val = 32'(val); step(); upd_valid = 1'b0;
  endtask

  task automatic do_take(int idx, int v1, int v2, int base, int op, string req);
    take_valid = 1'b1; take_idx = 2'(idx); #1;
    chk(req, take_ready, 1); chk(req, tk_v1, v1); chk(req, tk_v2, v2);
    chk(req, tk_dst, base); chk(req, tk_rob, base); chk(req, tk_op, op);
    chk(req, tk_f3, 2); chk(req, tk_f7, 4); chk(req, tk_imm, base); chk(req, tk_pc, base * 4);
    step(); take_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sel_ready", sel_ready, 1); chk("R1 sel_idx", sel_idx, 0);
    chk("R1 masks", rdy_mask, 0); chk("R1 valid", rdy_valid, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 4; i++) do_sel(i, "R2 lowest");
    chk("R2 full blocks select", sel_ready, 0);
  endtask

  task automatic t_insert();
    do_ins(0, 0, 0, 1, 0);
    chk("R4 ready after insert", rdy_mask, 8'b0000_0001);
    do_ins(1, 2, 3, 2, 1);
    do_ins(2, 0, 0, 3, 2);
    do_ins(3, 5, 5, 4, 3);
    chk("R7 group masks", rdy_mask, 8'b0100_0001);
    chk("R8 both valid", rdy_valid, 2'b11);
  endtask

  task automatic t_update();
    do_upd(2, 1010);
    chk("R5 one operand pending", rdy_mask, 8'b0100_0001);
    do_upd(3, 2020);
    chk("R5 second operand wakes", rdy_mask, 8'b0100_0011);
    do_upd(5, 77);
    chk("R5 both operands one update", rdy_mask, 8'b1100_0011);
  endtask

  task automatic t_take();
    do_take(1, 1010, 2020, 1, 2, "R6 payload");
    chk("R6 ready drops", rdy_mask, 8'b1100_0001);
    take_valid = 1'b1; take_idx = 2'd1; #1;
    chk("R6 not full", take_ready, 0);
    step(); take_valid = 1'b0;
    chk("R6 empty take no effect", rdy_mask, 8'b1100_0001);
    do_sel(1, "R6 empty take keeps slot free");
    do_take(0, 0, 0, 0, 1, "R6 payload slot0");
    chk("R8 group0 empty", rdy_valid, 2'b10);
    do_sel(0, "R3 reuse slot0");
  endtask

  task automatic t_multi();
    do_ins(0, 11, 11, 1, 20);
    do_ins(1, 11, 11, 2, 21);
    chk("R5 waiting", rdy_mask[3:0], 4'b0000);
    do_upd(11, 3030);
    chk("R5 multi-entry wake", rdy_mask[3:0], 4'b0011);
    do_take(0, 3030, 3030, 20, 1, "R5 values stored");
    do_take(1, 3030, 3030, 21, 2, "R5 values stored slot1");
  endtask

  task automatic t_same_cycle();
    do_sel(0, "R3 reuse after take");
    drive_ins(0, 9, 13, 1, 30);
    upd_valid = 1'b1; upd_tag = 6'd9; upd_val = 32'd44;
    step(); ins_valid = 1'b0; upd_valid = 1'b0;
    chk("R9 src2 still pending", rdy_mask[3:0], 4'b0000);
    do_upd(13, 55);
    chk("R9 ready after second", rdy_mask[3:0], 4'b0001);
    do_take(0, 44, 55, 30, 1, "R9 wake in insert cycle");
  endtask

  initial begin
    rst_n = 1'b0; sel_valid = 0; ins_valid = 0; upd_valid = 0; take_valid = 0;
    ins_idx = 0; ins_t1 = 0; ins_t2 = 0; ins_dst = 0; ins_rob = 0; ins_op = 0;
    ins_f3 = 0; ins_f7 = 0; ins_v1 = 0; ins_v2 = 0; ins_imm = 0; ins_pc = 0;
    upd_tag = 0; upd_val = 0; take_idx = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_fill();
    t_insert();
    t_update();
    t_take();
    t_multi();
    t_same_cycle();
    do_sel(0, "R2 lowest after frees");
    do_sel(1, "R2 next");
    chk("R2 all reserved", sel_ready, 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule